// File: doc/BRIEF.md
# Masked Pattern and Edge Trigger

This block watches a stream of sample words, each qualified by a valid strobe, and raises a trigger flag when a programmed condition holds. The condition is a level pattern over every input bit, where each bit is either compared against a programmed value or ignored. The pattern can be combined with an edge condition on one selected channel, and optionally with a second edge on another channel. Each edge can be set to look for a rising or a falling transition.

When both edge conditions are enabled, the two transitions must land in the same check interval. An interval is a fixed run of `CHECK_LEN` consecutive valid samples, counted from the last arm. The trigger is sticky. It also reports the index of the sample that satisfied the condition, counted in valid samples since the last arm. A narrow build (`EDGE_SRCS` of 8 or 4) shrinks the edge selectors so that only the lowest channels can serve as edge sources. This suits the faster capture modes, where fewer channels are available.

Top module: `pattern_edge_trigger`

## Requirements
- R1: While reset is held, and on the first cycle after it, `trig` is 0 and `trig_index` is 0.
- R2: A bit with `cfg_care` set to 1 must equal the matching bit of `cfg_value`. A bit with `cfg_care` set to 0 is ignored. With both edge enables at 0, the trigger fires on the first valid sample that matches.
- R3: `trig` is registered and rises on the clock edge that takes in the satisfying sample. `trig_index` then holds that sample's index. The first valid sample after an arm has index 0.
- R4: A cycle with `in_valid` at 0 is ignored. It is not counted, not compared, and does not become the previous sample for edge detection.
- R5: Edge A with `cfg_ea_rise`=1 is a change of channel `cfg_ea_sel` from 0 in the previous valid sample to 1 in the current one. With `cfg_ea_rise`=0 it is a change from 1 to 0. When edge A is the only enabled edge, the pattern must match on the same sample as the edge.
- R6: The first valid sample after reset or an arm has no predecessor, so it can never count as an edge.
- R7: With both edges enabled, the trigger fires on a sample when three things hold: the pattern matches on that sample, and edge A and edge B have each been seen within the current interval, up to and including that sample. Intervals are the valid-sample index ranges [k*CHECK_LEN, k*CHECK_LEN+CHECK_LEN-1]. Edges that fall in different intervals never combine.
- R8: With only edge B enabled, the unit behaves as a single edge trigger on `cfg_eb_sel` with polarity `cfg_eb_rise`.
- R9: Once `trig` is 1, it stays 1 and `trig_index` holds its value until an arm, whatever the later samples are.
- R10: A cycle with `arm` at 1 clears `trig`, `trig_index`, the sample index, the interval position, the seen-edge flags and the previous-sample history. The sample offered in that cycle is discarded.
- R11: The edge selectors are $clog2(EDGE_SRCS) bits wide and address channels 0 to EDGE_SRCS-1 only. Transitions on higher channels never satisfy an edge condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Clear and restart the trigger search |
| in_valid | input | 1 | Qualifies `in_data` for this cycle |
| in_data | input | WIDTH | Sample word |
| cfg_value | input | WIDTH | Required level for each compared bit |
| cfg_care | input | WIDTH | 1 = compare the bit, 0 = ignore it |
| cfg_ea_en | input | 1 | Enable edge A |
| cfg_ea_sel | input | SELW | Channel watched by edge A |
| cfg_ea_rise | input | 1 | Edge A polarity: 1 rising, 0 falling |
| cfg_eb_en | input | 1 | Enable edge B |
| cfg_eb_sel | input | SELW | Channel watched by edge B |
| cfg_eb_rise | input | 1 | Edge B polarity: 1 rising, 0 falling |
| trig | output | 1 | Sticky trigger flag |
| trig_index | output | IDXW | Valid-sample index of the satisfying sample |

## Verification
The bench builds two copies of the block. The first uses the full width of 16 channels with 16 edge sources and `CHECK_LEN`=4. With a four-sample interval, a bench of modest length can show one case where edges in neighbouring intervals fail to combine and another where edges in the same interval succeed. The second copy uses `EDGE_SRCS`=4, which gives 2-bit selectors. It runs on the same stimulus, so a transition on a channel beyond its reach can be shown to have no effect while the wide copy would react to it.

// File: rtl/pattern_edge_trigger.sv
module pattern_edge_trigger #(
  parameter int WIDTH     = 16,
  parameter int EDGE_SRCS = 16,
  parameter int CHECK_LEN = 4,
  parameter int IDXW      = 16,
  localparam int SELW = (EDGE_SRCS > 1) ? $clog2(EDGE_SRCS) : 1,
  localparam int CNTW = (CHECK_LEN > 1) ? $clog2(CHECK_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic [WIDTH-1:0] cfg_value,
  input  logic [WIDTH-1:0] cfg_care,
  input  logic             cfg_ea_en,
  input  logic [SELW-1:0]  cfg_ea_sel,
  input  logic             cfg_ea_rise,
  input  logic             cfg_eb_en,
  input  logic [SELW-1:0]  cfg_eb_sel,
  input  logic             cfg_eb_rise,
  output logic             trig,
  output logic [IDXW-1:0]  trig_index
);

  logic [EDGE_SRCS-1:0] prev;
  logic                 prev_ok;
  logic                 seen_a, seen_b;
  logic [CNTW-1:0]      slot;
  logic [IDXW-1:0]      count;

  wire [EDGE_SRCS-1:0] cur = in_data[EDGE_SRCS-1:0];

  wire pat_ok = ((in_data ^ cfg_value) & cfg_care) == '0;

  wire edge_a = prev_ok && (cur[cfg_ea_sel] != prev[cfg_ea_sel])
                        && (cur[cfg_ea_sel] == cfg_ea_rise);
  wire edge_b = prev_ok && (cur[cfg_eb_sel] != prev[cfg_eb_sel])
                        && (cur[cfg_eb_sel] == cfg_eb_rise);

  wire first_slot = (slot == '0);
  wire last_slot  = (slot == CNTW'(CHECK_LEN - 1));
  wire a_win = edge_a || (seen_a && !first_slot);
  wire b_win = edge_b || (seen_b && !first_slot);

  logic edge_ok;
  always_comb begin
    case ({cfg_ea_en, cfg_eb_en})
      2'b11:   edge_ok = a_win && b_win;
      2'b10:   edge_ok = edge_a;
      2'b01:   edge_ok = edge_b;
      default: edge_ok = 1'b1;
    endcase
  end

  wire fire = in_valid && pat_ok && edge_ok;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      prev       <= '0;
      prev_ok    <= 1'b0;
      seen_a     <= 1'b0;
      seen_b     <= 1'b0;
      slot       <= '0;
      count      <= '0;
      trig       <= 1'b0;
      trig_index <= '0;
    end else if (in_valid) begin
      prev    <= cur;
      prev_ok <= 1'b1;
      seen_a  <= a_win;
      seen_b  <= b_win;
      slot    <= last_slot ? '0 : slot + 1'b1;
      count   <= count + 1'b1;
      if (!trig && fire) begin
        trig       <= 1'b1;
        trig_index <= count;
      end
    end
  end

  assert_trig_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !arm) |=> trig);

  assert_index_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !arm) |=> $stable(trig_index));

  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!trig && trig_index == '0));

  assert_rise_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(in_valid));

  assert_rise_needs_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> ((($past(in_data) ^ $past(cfg_value)) & $past(cfg_care)) == '0));

endmodule

// File: tb/pattern_edge_trigger_tb.sv
module pattern_edge_trigger_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] value = '0, care = '0;
  logic        ea_en = 0, ea_rise = 0, eb_en = 0, eb_rise = 0;
  logic [3:0]  ea_sel = '0, eb_sel = '0;
  logic [1:0]  n_sel = '0;
  logic        trig, n_trig;
  logic [15:0] tidx, n_tidx;

  int applied = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pattern_edge_trigger #(.WIDTH(16), .EDGE_SRCS(16), .CHECK_LEN(4), .IDXW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_valid(valid), .in_data(din),
    .cfg_value(value), .cfg_care(care),
    .cfg_ea_en(ea_en), .cfg_ea_sel(ea_sel), .cfg_ea_rise(ea_rise),
    .cfg_eb_en(eb_en), .cfg_eb_sel(eb_sel), .cfg_eb_rise(eb_rise),
    .trig(trig), .trig_index(tidx));

  pattern_edge_trigger #(.WIDTH(16), .EDGE_SRCS(4), .CHECK_LEN(4), .IDXW(16)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_valid(valid), .in_data(din),
    .cfg_value(value), .cfg_care(care),
    .cfg_ea_en(ea_en), .cfg_ea_sel(n_sel), .cfg_ea_rise(ea_rise),
    .cfg_eb_en(1'b0), .cfg_eb_sel(2'd0), .cfg_eb_rise(1'b0),
    .trig(n_trig), .trig_index(n_tidx));

  // {arm, valid, data, exp_trig, exp_index}
  localparam logic [26:0] VEC [11] = '{
    {1'b1, 1'b1, 16'hA5C3, 1'b0, 8'd0},
    {1'b0, 1'b1, 16'h0000, 1'b0, 8'd0},
    {1'b0, 1'b0, 16'hA5C3, 1'b0, 8'd0},
    {1'b0, 1'b1, 16'hA5F4, 1'b0, 8'd0},
    {1'b0, 1'b1, 16'hA5F3, 1'b1, 8'd2},
    {1'b0, 1'b1, 16'h0000, 1'b1, 8'd2},
    {1'b1, 1'b1, 16'hA5C3, 1'b0, 8'd0},
    {1'b0, 1'b1, 16'h24C3, 1'b0, 8'd0},
    {1'b0, 1'b1, 16'hA5C3, 1'b1, 8'd1},
    {1'b1, 1'b0, 16'hA5C3, 1'b0, 8'd0},
    {1'b0, 1'b1, 16'hA503, 1'b1, 8'd0}
  };

  task automatic chk(input string tag, input logic gt, input logic [15:0] gi,
                     input logic et, input logic [15:0] ei);
    applied++;
    if (gt !== et || (et && gi !== ei)) begin
      fails++;
      $display("FAIL %s: trig=%0b index=%0d, expected trig=%0b index=%0d", tag, gt, gi, et, ei);
    end
  endtask

  task automatic step(input logic a, input logic v, input logic [15:0] d);
    arm = a; valid = v; din = d;
    @(negedge clk);
  endtask

  task automatic run(input logic a, input logic v, input logic [15:0] d,
                     input logic et, input logic [15:0] ei, input string tag);
    step(a, v, d);
    chk(tag, trig, tidx, et, ei);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 in reset", trig, tidx, 1'b0, 16'd0);
    if (tidx !== 16'd0) begin fails++; $display("FAIL R1: index=%0d expected 0", tidx); end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", trig, tidx, 1'b0, 16'd0);

    // R2 R3 R4 R9 R10: pattern only, bits 15:8 = A5 and 3:0 = 3 compared
    value = 16'hA5C3; care = 16'hFF0F;
    for (int i = 0; i < 11; i++) begin
      step(VEC[i][26], VEC[i][25], VEC[i][24:9]);
      chk($sformatf("R2/R3/R4/R9/R10 vector %0d", i), trig, tidx, VEC[i][8], {8'd0, VEC[i][7:0]});
    end

    // R5 R6: rising edge on channel 5 with bit 0 required high
    value = 16'h0001; care = 16'h0001; ea_en = 1; ea_sel = 4'd5; ea_rise = 1;
    run(1, 1, 16'h0001, 0, 0, "R10 arm");
    run(0, 1, 16'h0021, 0, 0, "R6 no edge on first sample");
    run(0, 1, 16'h0001, 0, 0, "R5 wrong polarity");
    run(0, 1, 16'h0020, 0, 0, "R5 edge without pattern");
    run(0, 1, 16'h0000, 0, 0, "R5 falling ignored");
    run(0, 0, 16'h0021, 0, 0, "R4 invalid ignored");
    run(0, 1, 16'h0021, 1, 4, "R5 rising edge with pattern");

    // R4 R5: falling polarity; an invalid sample must not become history
    ea_rise = 0;
    run(1, 0, 16'h0000, 0, 0, "R10 arm");
    run(0, 1, 16'h0021, 0, 0, "R6 first sample");
    run(0, 0, 16'h0001, 0, 0, "R4 invalid sample");
    run(0, 1, 16'h0021, 0, 0, "R4 invalid not used as history");
    run(0, 1, 16'h0001, 1, 2, "R5 falling edge");

    // R7: A rising on 2, B falling on 9, interval of 4 valid samples
    care = '0; ea_sel = 4'd2; ea_rise = 1; eb_en = 1; eb_sel = 4'd9; eb_rise = 0;
    run(1, 0, 16'h0000, 0, 0, "R10 arm");
    run(0, 1, 16'h0200, 0, 0, "R7 idx0");
    run(0, 1, 16'h0204, 0, 0, "R7 A alone");
    run(0, 1, 16'h0204, 0, 0, "R7 idx2");
    run(0, 1, 16'h0204, 0, 0, "R7 idx3");
    run(0, 1, 16'h0004, 0, 0, "R7 B in next interval does not combine");
    run(0, 1, 16'h0004, 0, 0, "R7 idx5");
    run(0, 1, 16'h0004, 0, 0, "R7 idx6");
    run(0, 1, 16'h0004, 0, 0, "R7 idx7");
    run(0, 1, 16'h0200, 0, 0, "R7 opposite edges");
    run(0, 1, 16'h0204, 0, 0, "R7 A in interval 2");
    run(0, 1, 16'h0004, 1, 10, "R7 B joins A in same interval");

    // R8: only edge B
    ea_en = 0;
    run(1, 0, 16'h0000, 0, 0, "R10 arm");
    run(0, 1, 16'h0200, 0, 0, "R8 idx0");
    run(0, 1, 16'h0000, 1, 1, "R8 single edge B");

    // R11: narrow copy watches channel 3 with a 2-bit selector
    ea_en = 1; eb_en = 0; ea_sel = 4'd7; ea_rise = 1; n_sel = 2'd3;
    step(1, 0, 16'h0000);
    step(0, 1, 16'h0000);
    chk("R11 narrow idle", n_trig, n_tidx, 0, 0);
    step(0, 1, 16'h0080);
    chk("R11 channel 7 unreachable in narrow", n_trig, n_tidx, 0, 0);
    chk("R11 wide copy sees channel 7", trig, tidx, 1, 1);
    step(0, 1, 16'h0088);
    chk("R11 narrow channel 3 edge", n_trig, n_tidx, 1, 2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule